// File: doc/BRIEF.md
# Edge-Capture Interrupt Controller

This block collects up to 32 interrupt inputs and turns their edges into pending
flags that software can inspect and acknowledge over a simple word-addressed
register bus. Every input is first brought into the clock domain by a
multi-flop synchronizer. It then passes through an optional per-bit inverter,
and a one-flop edge detector watches the result. A rising edge of the inverted
or uninverted level sets the bit's pending flag. Setting the inversion bit
therefore makes the falling edge of the raw wire the active one.

Pending flags that are also enabled are split by a per-bit routing register into
a normal-request vector and a fast-request vector. Each vector is OR-reduced
into a registered line toward the processor. The routing bit's sense is a
parameter, so that either 0 or 1 can mean "fast".

Two bus addresses have different meanings for reads and writes. The status
address reads the pending flags; writing 1s to it clears them. The source
address reads the synchronized, inverted input levels; writing 1s to it forces
pending flags on. In both cases, 0 bits in a write have no effect. Reads are
combinational from the address, and writes take effect at the next clock edge.

Register offsets (word addresses on `bus_addr`):

- 0: enable (read/write)
- 1: inversion (read/write)
- 2: routing (read/write)
- 3: normal-request vector (read only)
- 4: fast-request vector (read only)
- 5: status on read, clear on write
- 6: source level on read, force on write
- 7: unused

The block is controlled by one small write-decode step per cycle, not by a
state machine. It has no named states or transitions.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, the enable, inversion, routing and pending registers are all 0, and both `irq_o` and `fiq_o` are low.
- R2: With inversion 0, a rising edge of `src_raw[i]` sets pending bit i. The change is visible at the status address after the third rising clock edge that follows the input change (two synchronizer flops, then the capture flop). A pending bit never becomes 1 except through a captured edge or a force write.
- R3: With inversion bit i = 1, a falling edge of `src_raw[i]` sets pending bit i, and a rising edge does not. Writing the inversion bit so that the inverted level goes from 0 to 1 is itself seen as an edge.
- R4: Reading address 6 returns the synchronized raw inputs XOR the inversion register. A raw change appears there after two rising clock edges.
- R5: Writing address 6 sets every pending bit whose data bit is 1, at the next clock edge. Bits written 0 are unchanged.
- R6: Reading address 5 returns the pending bits. Writing address 5 clears every pending bit whose data bit is 1, at the next clock edge. Bits written 0 are unchanged.
- R7: If a clear write and a captured edge hit the same bit in the same cycle, the bit stays pending.
- R8: Address 3 reads pending & enable & normal-routed, and address 4 reads pending & enable & fast-routed. With the default parameter `DEST_ONE_FIQ = 1`, a routing bit of 1 selects fast and 0 selects normal. No bit is ever in both vectors.
- R9: `irq_o` and `fiq_o` equal the OR of the normal-request and fast-request vectors one clock earlier.
- R10: Addresses 0, 1 and 2 read back the last value written. Writes to addresses 3, 4 and 7 change nothing, and address 7 reads 0.
- R11: With enable 0, a pending bit drives no request and no output line, and it stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_raw | input | NSRC | Raw interrupt inputs, asynchronous to `clk` |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Registered OR of the normal-request vector |
| fiq_o | output | 1 | Registered OR of the fast-request vector |

## Verification
The timing of each result follows from the stage counts:

- A raw input change reaches the source read after two rising edges.
- It reaches the pending flags and the request reads after three rising edges.
- It reaches the output lines after four rising edges.
- A write reaches its register, or the pending flags, on the first edge.
- A write reaches the output lines on the second edge.

The bench keeps a behavioural model that advances once per rising edge, with those same delays. It compares the read data for the current address and both output lines at every falling edge, half a cycle after all state has settled.

Directed checks drive stimulus just after a falling edge and count whole edges before sampling. This places each sample on the exact cycle in which the result first becomes due.

// File: rtl/eic_pkg.sv
package eic_pkg;
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RG_ENABLE  = 3'd0,
        RG_POLAR   = 3'd1,
        RG_ROUTE   = 3'd2,
        RG_IRQREQ  = 3'd3,
        RG_FIQREQ  = 3'd4,
        RG_STATCLR = 3'd5,
        RG_SRCSET  = 3'd6,
        RG_SPARE   = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/eic_capture.sv
module eic_capture #(
    parameter int NSRC        = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] raw_in,
    input  logic [NSRC-1:0] pol_mask,
    output logic [NSRC-1:0] src_level,
    output logic [NSRC-1:0] edge_hit
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [NSRC-1:0] synced;
    logic [NSRC-1:0] prev_q;

    // one synchronizer chain per input bit
    for (genvar g = 0; g < NSRC; g++) begin : g_sync
        logic [TOP:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[TOP-1:0], raw_in[g]};
        end
        assign synced[g] = chain_q[TOP];
    end

    // inversion sits ahead of the edge detector
    assign src_level = synced ^ pol_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= src_level;
    end

    assign edge_hit = src_level & ~prev_q;
endmodule

// File: rtl/eic_pending.sv
module eic_pending #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] edge_hit,
    input  logic [NSRC-1:0] set_mask,
    input  logic [NSRC-1:0] clr_mask,
    output logic [NSRC-1:0] pend_q
);
    // clear first, then set: a fresh edge or force beats a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_mask) | edge_hit | set_mask;
    end
endmodule

// File: rtl/eic_regs.sv
module eic_regs
    import eic_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [NSRC-1:0]   bus_wdata,
    input  logic [NSRC-1:0]   pend_q,
    input  logic [NSRC-1:0]   src_level,
    input  logic [NSRC-1:0]   irq_vec,
    input  logic [NSRC-1:0]   fiq_vec,
    output logic [NSRC-1:0]   en_q,
    output logic [NSRC-1:0]   pol_q,
    output logic [NSRC-1:0]   dest_q,
    output logic [NSRC-1:0]   set_mask,
    output logic [NSRC-1:0]   clr_mask,
    output logic [NSRC-1:0]   bus_rdata
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(bus_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            pol_q  <= '0;
            dest_q <= '0;
        end else if (bus_wr) begin
            unique case (sel)
                RG_ENABLE: en_q   <= bus_wdata;
                RG_POLAR:  pol_q  <= bus_wdata;
                RG_ROUTE:  dest_q <= bus_wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (bus_wr) begin
            if (sel == RG_SRCSET)  set_mask = bus_wdata;
            if (sel == RG_STATCLR) clr_mask = bus_wdata;
        end
    end

    always_comb begin
        unique case (sel)
            RG_ENABLE:  bus_rdata = en_q;
            RG_POLAR:   bus_rdata = pol_q;
            RG_ROUTE:   bus_rdata = dest_q;
            RG_IRQREQ:  bus_rdata = irq_vec;
            RG_FIQREQ:  bus_rdata = fiq_vec;
            RG_STATCLR: bus_rdata = pend_q;
            RG_SRCSET:  bus_rdata = src_level;
            RG_SPARE:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/eic_route.sv
module eic_route #(
    parameter int NSRC         = 32,
    parameter bit DEST_ONE_FIQ = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pend_q,
    input  logic [NSRC-1:0] en_q,
    input  logic [NSRC-1:0] dest_q,
    output logic [NSRC-1:0] irq_vec,
    output logic [NSRC-1:0] fiq_vec,
    output logic            irq_o,
    output logic            fiq_o
);
    logic [NSRC-1:0] fast_sel;
    logic [NSRC-1:0] live;

    if (DEST_ONE_FIQ) begin : g_one_fast
        assign fast_sel = dest_q;
    end else begin : g_zero_fast
        assign fast_sel = ~dest_q;
    end

    assign live    = pend_q & en_q;
    assign irq_vec = live & ~fast_sel;
    assign fiq_vec = live & fast_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= |irq_vec;
            fiq_o <= |fiq_vec;
        end
    end
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
    import eic_pkg::*;
#(
    parameter int NSRC         = 32,
    parameter int SYNC_STAGES  = 2,
    parameter bit DEST_ONE_FIQ = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_raw,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [NSRC-1:0]   bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);
    logic [NSRC-1:0] src_level;
    logic [NSRC-1:0] edge_hit;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] pol_q;
    logic [NSRC-1:0] dest_q;
    logic [NSRC-1:0] set_mask;
    logic [NSRC-1:0] clr_mask;
    logic [NSRC-1:0] irq_vec;
    logic [NSRC-1:0] fiq_vec;

    eic_capture #(.NSRC(NSRC), .SYNC_STAGES(SYNC_STAGES)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (src_raw),
        .pol_mask (pol_q),
        .src_level(src_level),
        .edge_hit (edge_hit)
    );

    eic_pending #(.NSRC(NSRC)) u_pending (
        .clk     (clk),
        .rst_n   (rst_n),
        .edge_hit(edge_hit),
        .set_mask(set_mask),
        .clr_mask(clr_mask),
        .pend_q  (pend_q)
    );

    eic_regs #(.NSRC(NSRC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .pend_q   (pend_q),
        .src_level(src_level),
        .irq_vec  (irq_vec),
        .fiq_vec  (fiq_vec),
        .en_q     (en_q),
        .pol_q    (pol_q),
        .dest_q   (dest_q),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .bus_rdata(bus_rdata)
    );

    eic_route #(.NSRC(NSRC), .DEST_ONE_FIQ(DEST_ONE_FIQ)) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_q (pend_q),
        .en_q   (en_q),
        .dest_q (dest_q),
        .irq_vec(irq_vec),
        .fiq_vec(fiq_vec),
        .irq_o  (irq_o),
        .fiq_o  (fiq_o)
    );
endmodule

// File: rtl/eic_chk.sv
module eic_chk
    import eic_pkg::*;
#(
    parameter int NSRC = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] bus_addr,
    input logic              bus_wr,
    input logic [NSRC-1:0]   bus_wdata,
    input logic [NSRC-1:0]   edge_hit,
    input logic [NSRC-1:0]   set_mask,
    input logic [NSRC-1:0]   pend_q,
    input logic [NSRC-1:0]   en_q,
    input logic [NSRC-1:0]   irq_vec,
    input logic [NSRC-1:0]   fiq_vec,
    input logic              irq_o,
    input logic              fiq_o
);
    // R2
    pend_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~$past(pend_q) & ~$past(edge_hit) & ~$past(set_mask)) == '0);

    // R5
    force_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RG_SRCSET) |=> ((pend_q & $past(bus_wdata)) == $past(bus_wdata)));

    // R6
    clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RG_STATCLR) |=> ((pend_q & $past(bus_wdata) & ~$past(edge_hit)) == '0));

    // R7
    edge_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((pend_q & $past(edge_hit)) == $past(edge_hit)));

    // R8
    route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vec & fiq_vec) == '0);

    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vec != '0) |=> irq_o);

    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(irq_vec) != '0));

    // R9
    fiq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> ($past(fiq_vec) != '0));

    // R11
    mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |=> (!irq_o && !fiq_o));
endmodule

bind edge_irq_ctrl eic_chk #(.NSRC(NSRC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .edge_hit (edge_hit),
    .set_mask (set_mask),
    .pend_q   (pend_q),
    .en_q     (en_q),
    .irq_vec  (irq_vec),
    .fiq_vec  (fiq_vec),
    .irq_o    (irq_o),
    .fiq_o    (fiq_o)
);

// File: tb/tb_edge_irq_ctrl.sv
`timescale 1ns/100ps
module tb_edge_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_raw = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    edge_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_raw(src_raw), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    // behavioural reference: two sync stages, capture, pending, registered lines
    logic [31:0] m_s1, m_s2, m_prev, m_pend, m_en, m_pol, m_dest;
    logic        m_irq, m_fiq;

    always @(posedge clk or negedge rst_n) begin
        logic [31:0] lvl, hit, setv, clrv;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0;
            m_en = 0; m_pol = 0; m_dest = 0; m_irq = 0; m_fiq = 0;
        end else begin
            lvl  = m_s2 ^ m_pol;
            hit  = lvl & ~m_prev;
            setv = (bus_wr && bus_addr == 3'd6) ? bus_wdata : 32'h0;
            clrv = (bus_wr && bus_addr == 3'd5) ? bus_wdata : 32'h0;
            m_irq = |(m_pend & m_en & ~m_dest);
            m_fiq = |(m_pend & m_en & m_dest);
            m_pend = (m_pend & ~clrv) | hit | setv;
            m_prev = lvl;
            m_s2 = m_s1;
            m_s1 = src_raw;
            if (bus_wr && bus_addr == 3'd0) m_en   = bus_wdata;
            if (bus_wr && bus_addr == 3'd1) m_pol  = bus_wdata;
            if (bus_wr && bus_addr == 3'd2) m_dest = bus_wdata;
        end
    end

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_en;
            3'd1: return m_pol;
            3'd2: return m_dest;
            3'd3: return m_pend & m_en & ~m_dest;
            3'd4: return m_pend & m_en & m_dest;
            3'd5: return m_pend;
            3'd6: return m_s2 ^ m_pol;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string addr_tag(input logic [2:0] a);
        case (a)
            3'd3, 3'd4: return "R8";
            3'd5: return "R6";
            3'd6: return "R4";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!finished) begin
            check(addr_tag(bus_addr), bus_rdata, model_read(bus_addr));
            check("R9 irq_o", {31'h0, irq_o}, {31'h0, m_irq});
            check("R9 fiq_o", {31'h0, fiq_o}, {31'h0, m_fiq});
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #0.5;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step(1);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #0.1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic report();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 7; a++) peek(3'(a), 32'h0, "R1");
        check("R1 lines", {30'h0, irq_o, fiq_o}, 32'h0);

        // R10 readback and ignored writes
        bus_write(3'd0, 32'h0000_00FF);
        bus_write(3'd2, 32'h0000_00F0);
        bus_write(3'd3, 32'hFFFF_FFFF);
        bus_write(3'd7, 32'hFFFF_FFFF);
        peek(3'd0, 32'h0000_00FF, "R10 enable");
        peek(3'd2, 32'h0000_00F0, "R10 route");
        peek(3'd3, 32'h0, "R10 wr3");
        peek(3'd7, 32'h0, "R10 spare");

        // R2 rising edge on bit 0, three edges to pending
        src_raw[0] = 1'b1;
        step(2);
        peek(3'd5, 32'h0, "R2 early");
        peek(3'd6, 32'h1, "R4 level");
        step(1);
        peek(3'd5, 32'h1, "R2 captured");
        peek(3'd3, 32'h1, "R8 irq req");
        check("R9 not yet", {31'h0, irq_o}, 32'h0);
        step(1);
        check("R9 irq up", {31'h0, irq_o}, 32'h1);

        // R8 fast route on bit 5
        src_raw[5] = 1'b1;
        step(3);
        peek(3'd4, 32'h20, "R8 fiq req");
        peek(3'd5, 32'h21, "R6 status");
        step(1);
        check("R9 fiq up", {31'h0, fiq_o}, 32'h1);

        // R6 clear
        bus_write(3'd5, 32'h21);
        peek(3'd5, 32'h0, "R6 cleared");
        step(1);
        check("R9 lines down", {30'h0, irq_o, fiq_o}, 32'h0);

        // R5 force, R6 zero bits untouched
        bus_write(3'd6, 32'h300);
        peek(3'd5, 32'h300, "R5 forced");
        bus_write(3'd5, 32'h100);
        peek(3'd5, 32'h200, "R6 partial");

        // R3 inversion on bit 2
        bus_write(3'd1, 32'h4);
        peek(3'd6, 32'h25, "R4 inverted");
        step(1);
        peek(3'd5, 32'h204, "R3 polarity flip edge");
        bus_write(3'd5, 32'h4);
        src_raw[2] = 1'b1;
        step(3);
        peek(3'd5, 32'h200, "R3 rise ignored");
        peek(3'd6, 32'h21, "R4 level");
        src_raw[2] = 1'b0;
        step(3);
        peek(3'd5, 32'h204, "R3 fall captured");

        // R7 clear lands with edge on bit 1
        bus_write(3'd6, 32'h2);
        src_raw[1] = 1'b1;
        step(2);
        bus_write(3'd5, 32'h2);
        peek(3'd5, 32'h206, "R7 edge wins");
        bus_write(3'd5, 32'h2);
        peek(3'd5, 32'h204, "R7 later clear");

        // R8 routing bit moves bit 2 to fast
        bus_write(3'd2, 32'h0000_00F4);
        step(1);
        check("R8 fast line", {30'h0, irq_o, fiq_o}, 32'h1);

        // R11 enable off
        bus_write(3'd0, 32'h0);
        step(1);
        check("R11 lines", {30'h0, irq_o, fiq_o}, 32'h0);
        peek(3'd5, 32'h204, "R11 still pending");
        peek(3'd4, 32'h0, "R11 no request");

        // mixed traffic, model compared each cycle
        bus_write(3'd0, 32'hFFFF_FFFF);
        for (int i = 0; i < 600; i++) begin
            src_raw = src_raw ^ ($urandom() & $urandom() & $urandom());
            bus_addr = 3'($urandom_range(0, 7));
            bus_wdata = $urandom();
            bus_wr = ($urandom_range(0, 3) == 0);
            step(1);
        end
        bus_wr = 1'b0;
        step(2);
        report();
    end
endmodule